// File: doc/BRIEF.md
# Edge-Maskable Alert Controller

This block watches a group of general-purpose input pins and pulls a shared, active-low, open-drain alert line whenever an enabled transition is seen on any of them. Every pin has its own rising-edge and falling-edge block bits. Two complete sets of those bits arrive from outside, a normal set and a suspend set, and a bank-select input picks which set applies at the moment an edge is detected. A detected event is latched and keeps the alert asserted until it is cleared, whatever later happens to the masks or the pin. A thermal-fault input also latches an alert, and no mask can block it.

Clearing comes from one of two sources. The first is a soft-clear pulse from the register logic. The second is a won alert-response round on the serial bus. During that round the bus engine tells the block when a response byte starts and strobes each sampled data-line bit to it. The block sends its own address most significant bit first through an open-drain pull on the data line, and it compares each bit with what the bus actually carried. If the two differ, the block has lost to a lower address: it stops driving and keeps its alert. If all address bits match, the block has won and drops every pending event. Bus framing and the storage of the mask registers are handled elsewhere.

Top module: `edge_alert_ctrl`

## Requirements
- R1: After reset, alert_pull and sda_pull are both 0.
- R2: A pin change is seen through a two-flop synchronizer. An enabled transition makes alert_pull 1 on the third rising clock edge after the pin changes, and not earlier.
- R3: A rising pin edge latches an event only when the active rise block bit for that pin is 0. A falling edge latches an event only when the active fall block bit is 0. A block bit of 1 suppresses the event.
- R4: With bank_normal=1 the *_nrm block bits apply. With bank_normal=0 the *_sus block bits apply. The bank is evaluated in the cycle the edge is detected.
- R5: A latched event stays pending, and alert_pull stays 1, when block bits are later set, when the bank changes, or when the pin returns to its old level.
- R6: A soft_clr pulse clears all pending events. An edge detected in the same cycle as the pulse is still latched.
- R7: therm_fault=1 latches an alert that no block bit can suppress. If a clear occurs while the fault is still present, alert_pull is 0 for exactly one cycle and then returns to 1.
- R8: ara_begin has no effect while nothing is pending: sda_pull stays 0, and later strobes do not change any output.
- R9: While an alert is pending, ara_begin starts a round. During the round, sda_pull is 1 exactly when the current address bit is 0. The first bit is dev_addr[6], and each sda_strobe moves to the next lower bit.
- R10: If a strobed sda_in differs from the current address bit, the round ends: sda_pull goes to 0 and alert_pull stays 1.
- R11: If all seven strobed bits match dev_addr, every pending event is cleared and alert_pull is 0 from the next cycle, unless the thermal fault is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | PINS | Asynchronous monitored pins |
| bank_normal | input | 1 | 1 selects the normal block bits, 0 selects the suspend block bits |
| rise_blk_nrm | input | PINS | Normal-bank rising-edge block bits (1 = blocked) |
| fall_blk_nrm | input | PINS | Normal-bank falling-edge block bits (1 = blocked) |
| rise_blk_sus | input | PINS | Suspend-bank rising-edge block bits (1 = blocked) |
| fall_blk_sus | input | PINS | Suspend-bank falling-edge block bits (1 = blocked) |
| therm_fault | input | 1 | Thermal fault level, cannot be masked |
| soft_clr | input | 1 | One-cycle pulse that clears pending events |
| dev_addr | input | AW | This device's bus address |
| ara_begin | input | 1 | Pulse: an alert-response byte is starting |
| sda_strobe | input | 1 | Pulse: sda_in carries the sampled bus bit |
| sda_in | input | 1 | Sampled data-line level |
| alert_pull | output | 1 | 1 = pull the active-low alert line low |
| sda_pull | output | 1 | 1 = pull the data line low |

## Verification
The in-line assertions check several properties on every cycle. A pending bit never drops without a clear. A data-line pull only happens while the alert is asserted. A present thermal fault is followed by an asserted alert. A lost arbitration round leaves the alert asserted. Other behaviours need the bench's scenarios, which compare against a cycle model: the exact three-edge latency, the choice of bank, the one-cycle release before a thermal re-assertion, an edge that coincides with a clear, and a complete won or lost round against a chosen address.

// File: rtl/edge_alert_ctrl.sv
module edge_alert_ctrl #(
  parameter int PINS = 8,
  parameter int AW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic            bank_normal,
  input  logic [PINS-1:0] rise_blk_nrm,
  input  logic [PINS-1:0] fall_blk_nrm,
  input  logic [PINS-1:0] rise_blk_sus,
  input  logic [PINS-1:0] fall_blk_sus,
  input  logic            therm_fault,
  input  logic            soft_clr,
  input  logic [AW-1:0]   dev_addr,
  input  logic            ara_begin,
  input  logic            sda_strobe,
  input  logic            sda_in,
  output logic            alert_pull,
  output logic            sda_pull
);

  localparam int IW = (AW > 1) ? $clog2(AW) : 1;
  localparam logic [IW-1:0] TOP_BIT = IW'(AW - 1);

  logic [PINS-1:0] s1, s2, prev, pend;
  logic            therm_pend, arb_on;
  logic [IW-1:0]   bit_idx;

  logic [PINS-1:0] rise_blk, fall_blk, events;
  logic            cur_bit, bit_ok, win, clr;

  assign rise_blk = bank_normal ? rise_blk_nrm : rise_blk_sus;
  assign fall_blk = bank_normal ? fall_blk_nrm : fall_blk_sus;
  assign events   = (s2 & ~prev & ~rise_blk) | (~s2 & prev & ~fall_blk);

  assign cur_bit = dev_addr[bit_idx];
  assign bit_ok  = (sda_in == cur_bit);
  assign win     = arb_on & sda_strobe & bit_ok & (bit_idx == '0);
  assign clr     = soft_clr | win;

  assign alert_pull = (|pend) | therm_pend;
  assign sda_pull   = arb_on & ~cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1         <= '0;
      s2         <= '0;
      prev       <= '0;
      pend       <= '0;
      therm_pend <= 1'b0;
    end else begin
      s1         <= pin_in;
      s2         <= s1;
      prev       <= s2;
      pend       <= (clr ? '0 : pend) | events;
      therm_pend <= clr ? 1'b0 : (therm_pend | therm_fault);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_on  <= 1'b0;
      bit_idx <= TOP_BIT;
    end else if (soft_clr) begin
      arb_on  <= 1'b0;
    end else if (ara_begin && !arb_on && alert_pull) begin
      arb_on  <= 1'b1;
      bit_idx <= TOP_BIT;
    end else if (arb_on && sda_strobe) begin
      if (!bit_ok || bit_idx == '0) arb_on <= 1'b0;
      else bit_idx <= bit_idx - 1'b1;
    end
  end

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((pend & $past(pend)) == $past(pend)));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && events == '0) |=> (pend == '0));

  // R7
  therm_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_fault && !clr) |=> alert_pull);

  // R9
  drive_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> alert_pull);

  // R10
  lost_keeps_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_on && sda_strobe && !bit_ok && !soft_clr) |=> (alert_pull && !arb_on));

endmodule

// File: tb/sim_edge_alert_ctrl.sv
`timescale 1ns/1ps
module sim_edge_alert_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic bank_normal = 1'b1;
  logic [7:0] rise_blk_nrm = '1, fall_blk_nrm = '1, rise_blk_sus = '1, fall_blk_sus = '1;
  logic therm_fault = 1'b0, soft_clr = 1'b0;
  logic [6:0] dev_addr = 7'b0100101;
  logic ara_begin = 1'b0, sda_strobe = 1'b0, sda_in = 1'b1;
  logic alert_pull, sda_pull;

  edge_alert_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bank_normal(bank_normal),
    .rise_blk_nrm(rise_blk_nrm), .fall_blk_nrm(fall_blk_nrm),
    .rise_blk_sus(rise_blk_sus), .fall_blk_sus(fall_blk_sus),
    .therm_fault(therm_fault), .soft_clr(soft_clr), .dev_addr(dev_addr),
    .ara_begin(ara_begin), .sda_strobe(sda_strobe), .sda_in(sda_in),
    .alert_pull(alert_pull), .sda_pull(sda_pull));

  always #2.5 clk = ~clk;

  integer vectors = 0, errors = 0, cycles = 0;
  string req = "R1";

  logic [7:0] hist [$];
  logic [7:0] m_pend;
  bit m_th, m_arb;
  int m_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {8'h00, 8'h00, 8'h00};
      m_pend = '0; m_th = 0; m_arb = 0; m_idx = 6;
    end else begin
      logic [7:0] now_s, old_s, rb, fb, ev;
      bit cb, w, c, al;
      now_s = hist[hist.size()-2];
      old_s = hist[hist.size()-3];
      rb = bank_normal ? rise_blk_nrm : rise_blk_sus;
      fb = bank_normal ? fall_blk_nrm : fall_blk_sus;
      ev = 8'h00;
      for (int i = 0; i < 8; i++) begin
        if (now_s[i] && !old_s[i] && !rb[i]) ev[i] = 1'b1;
        if (!now_s[i] && old_s[i] && !fb[i]) ev[i] = 1'b1;
      end
      cb = dev_addr[m_idx];
      w  = m_arb && sda_strobe && (sda_in == cb) && (m_idx == 0);
      c  = soft_clr || w;
      al = (m_pend != 0) || m_th;
      if (soft_clr) m_arb = 0;
      else if (ara_begin && !m_arb && al) begin m_arb = 1; m_idx = 6; end
      else if (m_arb && sda_strobe) begin
        if (sda_in != cb || m_idx == 0) m_arb = 0;
        else m_idx = m_idx - 1;
      end
      m_pend = (c ? 8'h00 : m_pend) | ev;
      m_th = c ? 1'b0 : (m_th || therm_fault);
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    bit ea, es;
    cycles++;
    ea = (m_pend != 0) || m_th;
    es = m_arb && !dev_addr[m_idx];
    if (!rst_n) begin ea = 0; es = 0; end
    vectors++;
    if (alert_pull !== ea || sda_pull !== es) begin
      errors++;
      $display("FAIL %s: alert_pull=%b sda_pull=%b expected %b %b at cycle %0d",
               req, alert_pull, sda_pull, ea, es, cycles);
    end
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_pulse();
    soft_clr = 1'b1; tick(1); soft_clr = 1'b0; tick(1);
  endtask

  task automatic strobe(bit v);
    sda_in = v; sda_strobe = 1'b1; tick(1); sda_strobe = 1'b0; sda_in = 1'b1; tick(1);
  endtask

  initial begin
    req = "R1"; tick(3); rst_n = 1'b1; tick(2);
    // R3: blocked edges give nothing
    req = "R3"; pin_in[0] = 1; tick(5); pin_in[0] = 0; tick(5);
    // R2: latency of an enabled rising edge
    req = "R2"; rise_blk_nrm[0] = 0; pin_in[0] = 1; tick(6);
    // R6: clear
    req = "R6"; clear_pulse(); tick(2);
    // R3: falling enable
    req = "R3"; fall_blk_nrm[3] = 0; pin_in[3] = 1; tick(5); pin_in[3] = 0; tick(5);
    // R5: masks set, pin returns, bank flips
    req = "R5"; fall_blk_nrm[3] = 1; rise_blk_nrm[0] = 1; pin_in[3] = 1; tick(4);
    bank_normal = 0; tick(4); bank_normal = 1; tick(2);
    req = "R6"; clear_pulse(); tick(2);
    // R4: suspend bank
    req = "R4"; bank_normal = 0; rise_blk_sus[5] = 0; pin_in[5] = 1; tick(6);
    clear_pulse(); bank_normal = 1; pin_in[5] = 0; tick(5); pin_in[5] = 1; tick(6);
    bank_normal = 0; pin_in[5] = 0; tick(5);
    // R6: edge coincides with clear
    req = "R6"; rise_blk_nrm[1] = 0; pin_in[1] = 1; tick(2); soft_clr = 1; tick(1); soft_clr = 0; tick(4);
    clear_pulse(); rise_blk_nrm[1] = 1; bank_normal = 1; tick(2);
    // R7: thermal
    req = "R7"; therm_fault = 1; tick(4); clear_pulse(); tick(3);
    therm_fault = 0; tick(2); clear_pulse(); tick(2);
    // R8: response begin with nothing pending
    req = "R8"; ara_begin = 1; tick(1); ara_begin = 0; tick(1); strobe(0); strobe(0); tick(2);
    // R9 and R11: winning round
    req = "R9"; rise_blk_nrm[2] = 0; pin_in[2] = 1; tick(6);
    ara_begin = 1; tick(1); ara_begin = 0; tick(1);
    for (int b = 6; b >= 0; b--) begin
      req = (b == 0) ? "R11" : "R9";
      strobe(dev_addr[b]);
    end
    tick(3);
    // R10: losing round (bus carries 0 at bit 5 where own bit is 1)
    req = "R10"; pin_in[2] = 0; tick(4); pin_in[2] = 1; tick(6);
    ara_begin = 1; tick(1); ara_begin = 0; tick(1);
    strobe(dev_addr[6]); strobe(1'b0); strobe(1'b0); strobe(1'b1); tick(3);
    // R11: later winning turn
    req = "R11"; ara_begin = 1; tick(1); ara_begin = 0; tick(1);
    for (int b = 6; b >= 0; b--) strobe(dev_addr[b]);
    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule